// File: doc/BRIEF.md
# Two-Block Banked Coefficient Read Scheduler

This block sits in front of a coefficient store that is split into several single-port banks. Each bank can serve one read per clock cycle. A classification step works on two feature blocks, A and B, at the same time. Each block needs a data-dependent set of coefficients. The scheduler takes the request list of each block (an address and a valid flag per entry) and spreads the reads over the banks. Every bank with work left issues one read in every cycle. The requests of both blocks share those bank cycles. A bank is therefore busy for the number of reads that A and B together place on it. The whole job ends when the most heavily loaded bank is done, not after A's worst bank followed by B's worst bank.

The two low bits of a coefficient address select its bank, and the remaining bits form the row inside that bank. Each word a bank returns comes out on that bank's lane one cycle after the read was issued. It carries a tag naming the block and the request's position in that block's list. The single downstream feature and multiply-accumulate path uses the tag to pick the matching histogram element. When all reads of a job have been issued, the block raises a one-cycle completion flag. It also presents the number of cycles in which reads were issued.

Top module: `coef_fetch_sched`

## Requirements
- R1: After reset, `busy`, `done`, `cycleCount`, every `bankRdEn` bit and every `rdValid` bit are 0.
- R2: A request with address `a` is read from bank `a[1:0]` at row `a[7:2]` (the bank count is 4).
- R3: Every valid request of an accepted job is read exactly once. A request whose valid flag is 0 is never read. No bank issues a read while the block is idle.
- R4: Within one bank, all of block A's pending requests are served before any of block B's. Within the same block, requests are served in ascending list index.
- R5: `done` is high for exactly one cycle. It is asserted K cycles after the first cycle in which `busy` is high. K is the maximum over the banks of (A's requests to that bank + B's requests to that bank). At that time `cycleCount` equals K, and it holds that value until the next accepted start.
- R6: In the cycle after a bank's read enable is high, that bank's `rdValid` is high. Its `rdTag` is 0 for block A and 1 for block B, its `rdIdx` is the list index, and its `rdData` lane carries the data the bank returned.
- R7: A `start` pulse while `busy` is high has no effect. The request lists present at that moment are not read, and the running job's count and timing are unchanged.
- R8: A job with no valid request in either list raises `done` in the first cycle after the start is taken, with `cycleCount` equal to 0.

Ports follow in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture both request lists and begin a job (taken only when idle) |
| reqAddrA | input | 64 | Block A addresses, entry i at bits [8i+7:8i] |
| reqValidA | input | 8 | Block A valid flag per entry |
| reqAddrB | input | 64 | Block B addresses, entry i at bits [8i+7:8i] |
| reqValidB | input | 8 | Block B valid flag per entry |
| bankRdEn | output | 4 | Read enable, one bit per bank |
| bankRdAddr | output | 24 | Row address per bank, bank b at bits [6b+5:6b] |
| bankRdData | input | 64 | Read data from the banks, one cycle after enable, bank b at [16b+15:16b] |
| rdValid | output | 4 | Returned word valid, per bank lane |
| rdTag | output | 4 | Owning block per lane (0 = A, 1 = B) |
| rdIdx | output | 12 | List index per lane, bank b at bits [3b+2:3b] |
| rdData | output | 64 | Returned word per lane |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse once all reads of the job are issued |
| cycleCount | output | 5 | Number of cycles of the job in which reads were issued |

## Verification
The bench targets four kinds of error:
- **Combined versus summed load.** In one job, A's worst bank and B's worst bank are different banks. A scheduler that serves A and B one after the other would report 11 cycles there instead of 7.
- **Ordering inside one bank.** Both blocks are stacked on a single bank with interleaved valid flags. Letting B jump ahead or skipping a flagged-off entry out of order shows up as a wrong tag or index on the lane.
- **Empty and duplicate jobs.** An empty job and two blocks asking for the same address expose a scheduler that hangs with nothing to do, or that merges identical requests.
- **Start while busy.** A start pulse arrives mid-job with different lists. If it were taken, stray words would appear and the count would be wrong.

// File: rtl/coef_fetch_pkg.sv
package coef_fetch_pkg;
  typedef struct packed {
    logic load;   // capture request lists, arm pending masks
    logic issue;  // banks may issue this cycle
  } fetchStrobe_t;
endpackage

// File: rtl/coef_fetch_ctrl.sv
module coef_fetch_ctrl
  import coef_fetch_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pendEmpty,
  output fetchStrobe_t     strobe,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cycleCount
);
  logic running;

  always_comb begin
    strobe.load  = start && !running;
    strobe.issue = running && !pendEmpty;
  end

  assign done = running && pendEmpty;
  assign busy = running;

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      cycleCount <= '0;
    end else begin
      if (strobe.load) begin
        running    <= 1'b1;
        cycleCount <= '0;
      end else if (done) begin
        running <= 1'b0;
      end
      if (strobe.issue) cycleCount <= cycleCount + 1'b1;
    end
  end
endmodule

// File: rtl/coef_fetch_dp.sv
module coef_fetch_dp
  import coef_fetch_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int LIST_LEN  = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(LIST_LEN),
  localparam int ROW_W    = ADDR_W - BANK_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  fetchStrobe_t                  strobe,
  input  logic [LIST_LEN*ADDR_W-1:0]    reqAddrA,
  input  logic [LIST_LEN-1:0]           reqValidA,
  input  logic [LIST_LEN*ADDR_W-1:0]    reqAddrB,
  input  logic [LIST_LEN-1:0]           reqValidB,
  output logic                          pendEmpty,
  output logic [NUM_BANKS-1:0]          bankRdEn,
  output logic [NUM_BANKS*ROW_W-1:0]    bankRdAddr,
  input  logic [NUM_BANKS*DATA_W-1:0]   bankRdData,
  output logic [NUM_BANKS-1:0]          rdValid,
  output logic [NUM_BANKS-1:0]          rdTag,
  output logic [NUM_BANKS*IDX_W-1:0]    rdIdx,
  output logic [NUM_BANKS*DATA_W-1:0]   rdData
);
  logic [ADDR_W-1:0]   addrA [LIST_LEN];
  logic [ADDR_W-1:0]   addrB [LIST_LEN];
  logic [LIST_LEN-1:0] pendA, pendB;
  logic [LIST_LEN-1:0] grantA [NUM_BANKS];
  logic [LIST_LEN-1:0] grantB [NUM_BANKS];
  logic [LIST_LEN-1:0] clrA, clrB;

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int i = 0; i < LIST_LEN; i++) begin
        addrA[i] <= reqAddrA[i*ADDR_W +: ADDR_W];
        addrB[i] <= reqAddrB[i*ADDR_W +: ADDR_W];
      end
    end
  end

  always_comb begin
    clrA = '0;
    clrB = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      clrA = clrA | grantA[b];
      clrB = clrB | grantB[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendA <= '0;
      pendB <= '0;
    end else if (strobe.load) begin
      pendA <= reqValidA;
      pendB <= reqValidB;
    end else if (strobe.issue) begin
      pendA <= pendA & ~clrA;
      pendB <= pendB & ~clrB;
    end
  end

  assign pendEmpty = (pendA == '0) && (pendB == '0);
  assign rdData    = bankRdData;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [LIST_LEN-1:0] hitA, hitB;
    logic [IDX_W-1:0]    selA, selB;
    logic                anyA, anyB, pickB, issueHere;
    logic [ADDR_W-1:0]   chosen;
    logic                validQ, tagQ;
    logic [IDX_W-1:0]    idxQ;

    always_comb begin
      for (int i = 0; i < LIST_LEN; i++) begin
        hitA[i] = pendA[i] && (addrA[i][BANK_W-1:0] == BANK_W'(b));
        hitB[i] = pendB[i] && (addrB[i][BANK_W-1:0] == BANK_W'(b));
      end
      selA = '0;
      selB = '0;
      for (int i = LIST_LEN - 1; i >= 0; i--) begin
        if (hitA[i]) selA = IDX_W'(i);
        if (hitB[i]) selB = IDX_W'(i);
      end
    end

    assign anyA      = |hitA;
    assign anyB      = |hitB;
    assign pickB     = !anyA && anyB;
    assign issueHere = strobe.issue && (anyA || anyB);
    assign chosen    = pickB ? addrB[selB] : addrA[selA];

    assign grantA[b] = (issueHere && !pickB) ? (LIST_LEN'(1) << selA) : '0;
    assign grantB[b] = (issueHere && pickB)  ? (LIST_LEN'(1) << selB) : '0;

    assign bankRdEn[b]                   = issueHere;
    assign bankRdAddr[b*ROW_W +: ROW_W]  = chosen[ADDR_W-1:BANK_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ <= 1'b0;
        tagQ   <= 1'b0;
        idxQ   <= '0;
      end else begin
        validQ <= issueHere;
        if (issueHere) begin
          tagQ <= pickB;
          idxQ <= pickB ? selB : selA;
        end
      end
    end

    assign rdValid[b]              = validQ;
    assign rdTag[b]                = tagQ;
    assign rdIdx[b*IDX_W +: IDX_W] = idxQ;
  end
endmodule

// File: rtl/coef_fetch_sched.sv
module coef_fetch_sched
  import coef_fetch_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int LIST_LEN  = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(LIST_LEN),
  localparam int ROW_W    = ADDR_W - BANK_W,
  localparam int CNT_W    = $clog2(2*LIST_LEN + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [LIST_LEN*ADDR_W-1:0]  reqAddrA,
  input  logic [LIST_LEN-1:0]         reqValidA,
  input  logic [LIST_LEN*ADDR_W-1:0]  reqAddrB,
  input  logic [LIST_LEN-1:0]         reqValidB,
  output logic [NUM_BANKS-1:0]        bankRdEn,
  output logic [NUM_BANKS*ROW_W-1:0]  bankRdAddr,
  input  logic [NUM_BANKS*DATA_W-1:0] bankRdData,
  output logic [NUM_BANKS-1:0]        rdValid,
  output logic [NUM_BANKS-1:0]        rdTag,
  output logic [NUM_BANKS*IDX_W-1:0]  rdIdx,
  output logic [NUM_BANKS*DATA_W-1:0] rdData,
  output logic                        busy,
  output logic                        done,
  output logic [CNT_W-1:0]            cycleCount
);
  fetchStrobe_t strobe;
  logic         pendEmpty;

  coef_fetch_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .pendEmpty(pendEmpty),
    .strobe(strobe), .busy(busy), .done(done), .cycleCount(cycleCount)
  );

  coef_fetch_dp #(
    .NUM_BANKS(NUM_BANKS), .LIST_LEN(LIST_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .reqAddrA(reqAddrA), .reqValidA(reqValidA),
    .reqAddrB(reqAddrB), .reqValidB(reqValidB),
    .pendEmpty(pendEmpty), .bankRdEn(bankRdEn), .bankRdAddr(bankRdAddr),
    .bankRdData(bankRdData), .rdValid(rdValid), .rdTag(rdTag),
    .rdIdx(rdIdx), .rdData(rdData)
  );
endmodule

// File: rtl/coef_fetch_chk.sv
module coef_fetch_chk #(
  parameter int NUM_BANKS = 4,
  parameter int LIST_LEN  = 8,
  parameter int CNT_W     = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic [NUM_BANKS-1:0] bankRdEn,
  input logic [NUM_BANKS-1:0] rdValid,
  input logic                 busy,
  input logic                 done,
  input logic [CNT_W-1:0]     cycleCount
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && bankRdEn == '0 && rdValid == '0 && cycleCount == '0));

  assert_no_read_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bankRdEn == '0));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_in_job_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(cycleCount));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cycleCount <= CNT_W'(2*LIST_LEN));

  assert_lane_follows_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rdValid == $past(bankRdEn)));

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

bind coef_fetch_sched coef_fetch_chk #(
  .NUM_BANKS(NUM_BANKS), .LIST_LEN(LIST_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .bankRdEn(bankRdEn), .rdValid(rdValid),
  .busy(busy), .done(done), .cycleCount(cycleCount)
);

// File: tb/coef_fetch_sched_tb.sv
module coef_fetch_sched_tb;
  localparam int NB = 4, LL = 8, AW = 8, DW = 16;
  localparam int BW = 2, IW = 3, RW = AW - BW, CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LL*AW-1:0] reqAddrA, reqAddrB;
  logic [LL-1:0]    vA = '0, vB = '0;
  logic [NB-1:0]    bankRdEn, rdValid, rdTag;
  logic [NB*RW-1:0] bankRdAddr;
  logic [NB*DW-1:0] bankRdData, rdData;
  logic [NB*IW-1:0] rdIdx;
  logic busy, done;
  logic [CW-1:0] cycleCount;

  logic [AW-1:0] tA [LL];
  logic [AW-1:0] tB [LL];
  logic [DW-1:0] memQ [NB];
  logic [31:0]   expQ [NB][$];

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  coef_fetch_sched u_dut (
    .clk(clk), .rst(rst), .start(start),
    .reqAddrA(reqAddrA), .reqValidA(vA), .reqAddrB(reqAddrB), .reqValidB(vB),
    .bankRdEn(bankRdEn), .bankRdAddr(bankRdAddr), .bankRdData(bankRdData),
    .rdValid(rdValid), .rdTag(rdTag), .rdIdx(rdIdx), .rdData(rdData),
    .busy(busy), .done(done), .cycleCount(cycleCount)
  );

  function automatic logic [DW-1:0] bankWord(int b, int row);
    return DW'(b * 4096 + row * 7 + 11);
  endfunction

  always_comb begin
    for (int i = 0; i < LL; i++) begin
      reqAddrA[i*AW +: AW] = tA[i];
      reqAddrB[i*AW +: AW] = tB[i];
    end
    for (int b = 0; b < NB; b++) bankRdData[b*DW +: DW] = memQ[b];
  end

  // bank model: one-cycle read latency
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (bankRdEn[b]) memQ[b] <= bankWord(b, int'(bankRdAddr[b*RW +: RW]));
  end

  task automatic check(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compare every returned word against the per-bank expectation (R2 R4 R6)
  always @(negedge clk) begin
    if (!rst) begin
      for (int b = 0; b < NB; b++) begin
        if (rdValid[b]) begin
          logic [31:0] got;
          got = {12'd0, rdTag[b], rdIdx[b*IW +: IW], rdData[b*DW +: DW]};
          if (expQ[b].size() == 0) begin
            check(1'b0, "R3 unexpected read", int'(got), -1);
          end else begin
            logic [31:0] want;
            want = expQ[b].pop_front();
            check(got == want, "R2/R4/R6 lane word", int'(got), int'(want));
          end
        end
      end
    end
  end

  // driver: computes expectation, runs a job, optional mid-job start (R7)
  task automatic runJob(bit poke, string label);
    int cnt [NB];
    int expK = 0;
    int n = 0;
    logic [AW-1:0] saveA [LL];
    logic [LL-1:0] saveV;
    for (int b = 0; b < NB; b++) begin
      cnt[b] = 0;
      for (int i = 0; i < LL; i++)
        if (vA[i] && int'(tA[i][BW-1:0]) == b) begin
          expQ[b].push_back({12'd0, 1'b0, IW'(i), bankWord(b, int'(tA[i][AW-1:BW]))});
          cnt[b]++;
        end
      for (int i = 0; i < LL; i++)
        if (vB[i] && int'(tB[i][BW-1:0]) == b) begin
          expQ[b].push_back({12'd0, 1'b1, IW'(i), bankWord(b, int'(tB[i][AW-1:BW]))});
          cnt[b]++;
        end
      if (cnt[b] > expK) expK = cnt[b];
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 300) begin
      if (poke && n == 2) begin
        start = 1'b1;
        saveV = vA;
        for (int i = 0; i < LL; i++) begin saveA[i] = tA[i]; tA[i] = ~tA[i]; end
        vA = '1;
      end else if (poke && n == 3) begin
        start = 1'b0;
        vA = saveV;
        for (int i = 0; i < LL; i++) tA[i] = saveA[i];
      end
      @(negedge clk);
      n++;
    end
    $display("[TB] job %s: expected %0d cycles", label, expK);
    check(done == 1'b1, "R5 done seen", int'(done), 1);
    check(n == expK, "R5 done timing (max of per-bank sums)", n, expK);
    check(int'(cycleCount) == expK, "R5 cycleCount", int'(cycleCount), expK);
    if (poke) check(int'(cycleCount) == expK, "R7 start while busy ignored", int'(cycleCount), expK);
    if (expK == 0) check(n == 0 && cycleCount == 0, "R8 empty job", n, 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R5 single done pulse", int'({busy, done}), 0);
    for (int b = 0; b < NB; b++)
      check(expQ[b].size() == 0, "R3 all valid requests read", expQ[b].size(), 0);
    check(int'(cycleCount) == expK, "R5 count held after done", int'(cycleCount), expK);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < LL; i++) begin tA[i] = '0; tB[i] = '0; end
    for (int b = 0; b < NB; b++) memQ[b] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && cycleCount == 0, "R1 reset state", int'({busy, done}), 0);
    check(bankRdEn == 0 && rdValid == 0, "R1 reset lanes", int'({bankRdEn, rdValid}), 0);

    // combined load: A worst 6 on bank0, B worst 5 on bank1, bank1 sum 7; poke start mid-job (R7)
    for (int i = 0; i < 6; i++) tA[i] = AW'(i * 4);
    tA[6] = 8'h21; tA[7] = 8'h25;
    for (int i = 0; i < 5; i++) tB[i] = AW'(8'h31 + i * 4);
    tB[5] = 8'h52; tB[6] = 8'h56; tB[7] = 8'h5A;
    vA = '1; vB = '1;
    runJob(1'b1, "split-worst");

    // ordering inside one bank with interleaved valid flags (R4, R3)
    for (int i = 0; i < LL; i++) begin tA[i] = AW'(3 + 4 * i); tB[i] = AW'(8'h83 + 4 * i); end
    vA = 8'b1010_0101; vB = 8'b0101_1010;
    runJob(1'b0, "one-bank");

    // nothing valid (R8)
    vA = '0; vB = '0;
    runJob(1'b0, "empty");

    // duplicate addresses across blocks
    for (int i = 0; i < LL; i++) begin tA[i] = 8'h11; tB[i] = 8'h11; end
    vA = 8'h0F; vB = 8'h03;
    runJob(1'b0, "duplicates");

    // scattered full lists
    for (int i = 0; i < LL; i++) begin tA[i] = AW'(i * 37 + 5); tB[i] = AW'(i * 53 + 2); end
    vA = '1; vB = '1;
    runJob(1'b0, "scattered");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule